// File: doc/BRIEF.md
# Write-Through Word Cache with Block Refill

This block is a direct-mapped data cache that sits between a processor port and main memory. Each entry keeps one data word, the upper address bits as a tag, a valid flag and one parity bit per byte. The processor presents word addresses with reads or byte-enabled stores. A read that finds its word resident and clean is answered combinationally in the same cycle. Every store is forwarded at once to a memory write port. A store that finds its word resident also patches the cached copy.

A read that misses asks an external fill engine for the aligned block of `FILL_WORDS` consecutive words around the missing address. The engine streams that block back in address order, and each beat lands in its own entry. A read whose tag matches but whose stored parity disagrees with the data raises a parity flag and is refetched like a miss. A separate invalidate port clears the valid flag of a single entry. Invalidation therefore works on one word while refills work on whole blocks.

Top module: `wt_word_cache`

## Requirements
- R1: After reset every entry is invalid: with no request, `cpu_ack`, `fill_req`, `mem_we` and `par_err` are low, and the first read of any address misses.
- R2: A read whose entry is valid, whose stored tag equals the address bits above the index (the index is the low `INDEX_W` bits of the word address), and whose parity is clean raises `cpu_ack` in the same cycle, with `cpu_rdata` equal to the stored word.
- R3: A read miss while no refill is running holds `cpu_ack` low and raises `fill_req` for exactly that cycle. `fill_addr` is the request address with its low log2(`FILL_WORDS`) bits cleared.
- R4: During a refill, the k-th `fill_valid` beat (k counted from 0) is written to the word at block base + k, with the block's tag, the supplied parity and the valid flag set. After the last beat, every word of the block hits.
- R5: While a refill runs, a read of a word not yet delivered stays unacknowledged until the cycle after its beat. A read that hits another entry is acknowledged. A store is neither acknowledged nor written to memory.
- R6: A store outside a refill is acknowledged in the same cycle and drives `mem_we` high, with `mem_addr`, `mem_wdata` and `mem_be` equal to the request.
- R7: A store that hits replaces only the bytes whose `cpu_be` bit is set (bit b selects data bits 8b+7 down to 8b) and regenerates parity for those bytes. A later read returns the merged word.
- R8: A store that misses changes no entry, so a later read of that address misses.
- R9: The parity bit for byte b is the XOR of the byte's eight bits. Stores generate it; refills take it from `fill_par`. A read whose tag matches but where any byte disagrees with its parity bit raises `par_err`, withholds `cpu_ack` and starts a refill as a miss does.
- R10: `inv_en` with a word address clears that one entry's valid flag at the next clock edge. Neighbouring words of the same block keep hitting.
- R11: Two addresses that share an index but differ in tag evict each other, and a read of the evicted one misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = read |
| cpu_be | input | DATA_W/8 | Store byte enables |
| cpu_addr | input | TAG_W+INDEX_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ack` on reads |
| cpu_ack | output | 1 | Request completes this cycle |
| par_err | output | 1 | Tag-matching read with bad parity |
| mem_we | output | 1 | Write-through strobe |
| mem_addr | output | TAG_W+INDEX_W | Write-through word address |
| mem_wdata | output | DATA_W | Write-through data |
| mem_be | output | DATA_W/8 | Write-through byte enables |
| fill_req | output | 1 | One-cycle refill request |
| fill_addr | output | TAG_W+INDEX_W | Aligned base word address of the block |
| fill_valid | input | 1 | Refill beat valid |
| fill_data | input | DATA_W | Refill beat data |
| fill_par | input | DATA_W/8 | Refill beat parity, one bit per byte |
| inv_en | input | 1 | Invalidate one entry |
| inv_addr | input | TAG_W+INDEX_W | Word address to invalidate |

## Verification
The embedded properties watch every cycle for rules of sequencing and storage. A refill request lasts one cycle and puts the sequencer into its busy state. The beat counter rests at zero when idle and returns to idle after the last beat. No store reaches memory during a refill. A parity flag never comes with an acknowledge. Each array write leaves the written tag, data and valid flag in place, and an invalidate leaves its entry cleared. Whether the right data comes back is shown only by the bench scenarios. These cover the merging of every one of the sixteen byte-enable patterns, the exact cycle a held read is released during a stream, parity recovery for both the requested word and a neighbour, aliasing between tags, and the effect of a single invalidation on the rest of its block.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

   typedef enum logic {
      WTC_IDLE = 1'b0,
      WTC_FILL = 1'b1
   } wtc_state_e;

endpackage

// File: rtl/wtc_bytepar.sv
module wtc_bytepar #(
   parameter int BYTES = 4
) (
   input  logic [8*BYTES-1:0] data_i,
   output logic [BYTES-1:0]   par_o
);

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign par_o[b] = ^data_i[8*b +: 8];
   end

endmodule

// File: rtl/wtc_store.sv
module wtc_store #(
   parameter int INDEX_W = 8,
   parameter int TAG_W   = 16,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INDEX_W-1:0] rd_idx,
   output logic               rd_valid,
   output logic [TAG_W-1:0]   rd_tag,
   output logic [DATA_W-1:0]  rd_data,
   output logic [DATA_W/8-1:0] rd_par,
   input  logic               wr_en,
   input  logic [INDEX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0]   wr_tag,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [DATA_W/8-1:0] wr_par,
   input  logic               inv_en,
   input  logic [INDEX_W-1:0] inv_idx
);

   localparam int DEPTH = 1 << INDEX_W;
   localparam int BYTES = DATA_W / 8;

   logic [DATA_W-1:0] data_q [DEPTH];
   logic [TAG_W-1:0]  tag_q  [DEPTH];
   logic [BYTES-1:0]  par_q  [DEPTH];
   logic [DEPTH-1:0]  valid_q;

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = data_q[rd_idx];
   assign rd_par   = par_q[rd_idx];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         data_q[wr_idx] <= wr_data;
         tag_q[wr_idx]  <= wr_tag;
         par_q[wr_idx]  <= wr_par;
      end
   end

   // invalidate is applied last so it wins a same-entry collision
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         if (wr_en) valid_q[wr_idx] <= 1'b1;
         if (inv_en) valid_q[inv_idx] <= 1'b0;
      end
   end

   a_r10_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
      inv_en |=> !valid_q[$past(inv_idx)]);

   a_r4_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(inv_en && inv_idx == wr_idx)) |=>
         (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));

   a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (data_q[$past(wr_idx)] == $past(wr_data)
                 && par_q[$past(wr_idx)] == $past(wr_par)));

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
   import wtc_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int LINE_W = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic [ADDR_W-LINE_W-1:0] start_blk_i,
   input  logic                     beat_i,
   output logic                     busy_o,
   output logic [ADDR_W-1:0]        beat_addr_o
);

   localparam int            BLK_W    = ADDR_W - LINE_W;
   localparam logic [LINE_W-1:0] LAST_BEAT = {LINE_W{1'b1}};

   wtc_state_e        state_q;
   logic [LINE_W-1:0] cnt_q;
   logic [BLK_W-1:0]  blk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WTC_IDLE;
         cnt_q   <= '0;
         blk_q   <= '0;
      end else begin
         unique case (state_q)
            WTC_IDLE: begin
               if (start_i) begin
                  state_q <= WTC_FILL;
                  blk_q   <= start_blk_i;
                  cnt_q   <= '0;
               end
            end
            WTC_FILL: begin
               if (beat_i) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == LAST_BEAT) state_q <= WTC_IDLE;
               end
            end
            default: state_q <= WTC_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q == WTC_FILL);
   assign beat_addr_o = {blk_q, cnt_q};

   a_r4_cnt_rests: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> cnt_q == '0);

   a_r4_block_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && beat_i && cnt_q == LAST_BEAT) |=> !busy_o);

   a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && cnt_q == '0));

endmodule

// File: rtl/wt_word_cache.sv
module wt_word_cache #(
   parameter int DATA_W     = 32,
   parameter int TAG_W      = 16,
   parameter int INDEX_W    = 8,
   parameter int FILL_WORDS = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cpu_req,
   input  logic                     cpu_we,
   input  logic [DATA_W/8-1:0]      cpu_be,
   input  logic [TAG_W+INDEX_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0]        cpu_wdata,
   output logic [DATA_W-1:0]        cpu_rdata,
   output logic                     cpu_ack,
   output logic                     par_err,
   output logic                     mem_we,
   output logic [TAG_W+INDEX_W-1:0] mem_addr,
   output logic [DATA_W-1:0]        mem_wdata,
   output logic [DATA_W/8-1:0]      mem_be,
   output logic                     fill_req,
   output logic [TAG_W+INDEX_W-1:0] fill_addr,
   input  logic                     fill_valid,
   input  logic [DATA_W-1:0]        fill_data,
   input  logic [DATA_W/8-1:0]      fill_par,
   input  logic                     inv_en,
   input  logic [TAG_W+INDEX_W-1:0] inv_addr
);

   localparam int ADDR_W = TAG_W + INDEX_W;
   localparam int BYTES  = DATA_W / 8;
   localparam int LINE_W = $clog2(FILL_WORDS);

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0) begin : g_bad_data_w
      $error("wt_word_cache: DATA_W must be a whole number of bytes");
   end
   if (FILL_WORDS < 2 || (1 << LINE_W) != FILL_WORDS) begin : g_bad_fill
      $error("wt_word_cache: FILL_WORDS must be a power of two, at least 2");
   end
   if (LINE_W > INDEX_W) begin : g_bad_index
      $error("wt_word_cache: a refill block may not exceed the cache");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wt_word_cache: TAG_W must be at least 1");
   end

   logic [INDEX_W-1:0] cpu_idx;
   logic [TAG_W-1:0]   cpu_tag;
   assign cpu_idx = cpu_addr[INDEX_W-1:0];
   assign cpu_tag = cpu_addr[ADDR_W-1:INDEX_W];

   // storage read and hit detection
   logic              rd_valid;
   logic [TAG_W-1:0]  rd_tag;
   logic [DATA_W-1:0] rd_data;
   logic [BYTES-1:0]  rd_par;
   logic [BYTES-1:0]  rd_par_calc;
   logic              tag_match;
   logic              par_bad;
   logic              hit;

   wtc_bytepar #(.BYTES(BYTES)) u_rd_par (
      .data_i (rd_data),
      .par_o  (rd_par_calc)
   );

   assign tag_match = rd_valid && (rd_tag == cpu_tag);
   assign par_bad   = |(rd_par_calc ^ rd_par);
   assign hit       = tag_match && !par_bad;

   // refill sequencer
   logic              fill_busy;
   logic              miss_start;
   logic [ADDR_W-1:0] beat_addr;

   assign miss_start = cpu_req && !cpu_we && !hit && !fill_busy;

   wtc_ctrl #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (miss_start),
      .start_blk_i (cpu_addr[ADDR_W-1:LINE_W]),
      .beat_i      (fill_valid),
      .busy_o      (fill_busy),
      .beat_addr_o (beat_addr)
   );

   // processor side
   logic read_done;
   logic write_done;
   logic store_hit;

   assign read_done  = cpu_req && !cpu_we && hit;
   assign write_done = cpu_req && cpu_we && !fill_busy;
   assign store_hit  = write_done && tag_match;

   assign cpu_ack   = read_done || write_done;
   assign cpu_rdata = rd_data;
   assign par_err   = cpu_req && !cpu_we && tag_match && par_bad;

   assign mem_we    = write_done;
   assign mem_addr  = cpu_addr;
   assign mem_wdata = cpu_wdata;
   assign mem_be    = cpu_be;

   assign fill_req  = miss_start;
   assign fill_addr = {cpu_addr[ADDR_W-1:LINE_W], {LINE_W{1'b0}}};

   // byte merge for store hits: untouched bytes keep their old parity
   logic [BYTES-1:0]  wdata_par;
   logic [DATA_W-1:0] mrg_data;
   logic [BYTES-1:0]  mrg_par;

   wtc_bytepar #(.BYTES(BYTES)) u_wr_par (
      .data_i (cpu_wdata),
      .par_o  (wdata_par)
   );

   for (genvar b = 0; b < BYTES; b++) begin : g_merge
      assign mrg_data[8*b +: 8] = cpu_be[b] ? cpu_wdata[8*b +: 8] : rd_data[8*b +: 8];
      assign mrg_par[b]         = cpu_be[b] ? wdata_par[b] : rd_par[b];
   end

   // single array write port shared by refill beats and store hits
   logic               beat_wr;
   logic               wr_en;
   logic [INDEX_W-1:0] wr_idx;
   logic [TAG_W-1:0]   wr_tag;
   logic [DATA_W-1:0]  wr_data;
   logic [BYTES-1:0]   wr_par;

   assign beat_wr = fill_busy && fill_valid;
   assign wr_en   = beat_wr || store_hit;
   assign wr_idx  = beat_wr ? beat_addr[INDEX_W-1:0] : cpu_idx;
   assign wr_tag  = beat_wr ? beat_addr[ADDR_W-1:INDEX_W] : cpu_tag;
   assign wr_data = beat_wr ? fill_data : mrg_data;
   assign wr_par  = beat_wr ? fill_par : mrg_par;

   wtc_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (cpu_idx),
      .rd_valid (rd_valid),
      .rd_tag   (rd_tag),
      .rd_data  (rd_data),
      .rd_par   (rd_par),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_tag   (wr_tag),
      .wr_data  (wr_data),
      .wr_par   (wr_par),
      .inv_en   (inv_en),
      .inv_idx  (inv_addr[INDEX_W-1:0])
   );

   a_r5_no_store_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
      fill_busy |-> !mem_we);

   a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |=> !fill_req);

   a_r9_perr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      par_err |-> (!cpu_ack && (fill_busy || fill_req)));

endmodule

// File: tb/wt_word_cache_test.sv
module wt_word_cache_test;

   localparam int CLK_P   = 10;
   localparam int IW      = 4;
   localparam int TW      = 4;
   localparam int AW      = IW + TW;
   localparam int NW      = 8;
   localparam int ENTRIES = 1 << IW;

   logic          clk;
   logic          rst_n;
   logic          cpu_req;
   logic          cpu_we;
   logic [3:0]    cpu_be;
   logic [AW-1:0] cpu_addr;
   logic [31:0]   cpu_wdata;
   logic [31:0]   cpu_rdata;
   logic          cpu_ack;
   logic          par_err;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata;
   logic [3:0]    mem_be;
   logic          fill_req;
   logic [AW-1:0] fill_addr;
   logic          fill_valid;
   logic [31:0]   fill_data;
   logic [3:0]    fill_par;
   logic          inv_en;
   logic [AW-1:0] inv_addr;

   wt_word_cache #(.DATA_W(32), .TAG_W(TW), .INDEX_W(IW), .FILL_WORDS(NW)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
      .par_err(par_err), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_be(mem_be), .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid),
      .fill_data(fill_data), .fill_par(fill_par), .inv_en(inv_en), .inv_addr(inv_addr)
   );

   initial clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model of the cache contents
   bit          mv [ENTRIES];
   int          mt [ENTRIES];
   logic [31:0] md [ENTRIES];
   logic [3:0]  mb [ENTRIES];

   function automatic logic [31:0] pat(input int w);
      logic [7:0] x;
      x = 8'(w);
      return {x, x ^ 8'h3C, ~x, x + 8'h71};
   endfunction

   function automatic logic [3:0] bpar(input logic [31:0] d);
      logic [3:0] p;
      for (int b = 0; b < 4; b++) p[b] = ^d[8*b +: 8];
      return p;
   endfunction

   function automatic bit tagm(input int a);
      return mv[a % ENTRIES] && mt[a % ENTRIES] == (a / ENTRIES);
   endfunction

   function automatic bit mhit(input int a);
      return tagm(a) && mb[a % ENTRIES] == 4'h0;
   endfunction

   function automatic bit mperr(input int a);
      return tagm(a) && mb[a % ENTRIES] != 4'h0;
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic rd(input int a, input string rq);
      @(negedge clk);
      cpu_req = 1; cpu_we = 0; cpu_be = 4'h0; cpu_addr = AW'(a);
      #1;
      chk(cpu_ack == 1'b1, rq, 32'(cpu_ack), 32'd1);
      chk(cpu_rdata == md[a % ENTRIES], rq, cpu_rdata, md[a % ENTRIES]);
      chk(fill_req == 1'b0 && par_err == 1'b0, rq, {fill_req, par_err}, 32'd0);
   endtask

   // stream one block; probe exercises R5 with other requests mid-stream
   task automatic feed(input int base, input int a, input int bad_k, input bit probe);
      for (int k = 0; k < NW; k++) begin
         int idx;
         @(negedge clk);
         fill_valid = 1;
         fill_data  = pat(base + k);
         fill_par   = bpar(pat(base + k)) ^ ((k == bad_k) ? 4'b0001 : 4'b0000);
         if (probe && k == 1) begin
            cpu_we = 1; cpu_be = 4'hF; cpu_addr = AW'(a ^ 8'hC0); cpu_wdata = 32'hDEADBEEF;
            #1;
            chk(cpu_ack == 1'b0 && mem_we == 1'b0, "R5 store stalled", {cpu_ack, mem_we}, 32'd0);
         end else if (probe && k == 2) begin
            cpu_we = 0; cpu_addr = AW'(a ^ 8);
            #1;
            chk(cpu_ack == 1'b1, "R5 hit during fill", 32'(cpu_ack), 32'd1);
            chk(cpu_rdata == md[(a ^ 8) % ENTRIES], "R5 hit data", cpu_rdata, md[(a ^ 8) % ENTRIES]);
         end else begin
            cpu_we = 0; cpu_addr = AW'(a);
            #1;
            chk(cpu_ack == mhit(a), "R5 held read", 32'(cpu_ack), 32'(mhit(a)));
            chk(par_err == mperr(a), "R9 during fill", 32'(par_err), 32'(mperr(a)));
            chk(fill_req == 1'b0, "R3 no request while busy", 32'(fill_req), 32'd0);
         end
         idx = (base + k) % ENTRIES;
         mv[idx] = 1; mt[idx] = (base + k) / ENTRIES; md[idx] = pat(base + k);
         mb[idx] = (k == bad_k) ? 4'b0001 : 4'b0000;
      end
   endtask

   task automatic read_fill(input int a, input int bad_k, input bit probe, input string rq);
      int base;
      base = a & ~(NW - 1);
      @(negedge clk);
      cpu_req = 1; cpu_we = 0; cpu_be = 4'h0; cpu_addr = AW'(a);
      #1;
      chk(cpu_ack == 1'b0, rq, 32'(cpu_ack), 32'd0);
      chk(fill_req == 1'b1, rq, 32'(fill_req), 32'd1);
      chk(fill_addr == AW'(base), "R3 aligned base", 32'(fill_addr), 32'(base));
      chk(par_err == mperr(a), "R9 at request", 32'(par_err), 32'(mperr(a)));
      feed(base, a, bad_k, probe);
      @(negedge clk);
      fill_valid = 0; cpu_we = 0; cpu_addr = AW'(a);
      #1;
      while (mperr(a)) begin
         chk(par_err == 1'b1 && cpu_ack == 1'b0, "R9 parity miss", {par_err, cpu_ack}, 32'd2);
         chk(fill_req == 1'b1, "R9 refetch", 32'(fill_req), 32'd1);
         feed(base, a, -1, 0);
         @(negedge clk);
         fill_valid = 0;
         #1;
      end
      chk(cpu_ack == 1'b1, "R4 hit after block", 32'(cpu_ack), 32'd1);
      chk(cpu_rdata == md[a % ENTRIES], "R4 block data", cpu_rdata, md[a % ENTRIES]);
   endtask

   task automatic access(input int a, input string rq);
      if (mhit(a)) rd(a, rq);
      else read_fill(a, -1, 0, rq);
   endtask

   task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
      int i;
      @(negedge clk);
      cpu_req = 1; cpu_we = 1; cpu_be = be; cpu_addr = AW'(a); cpu_wdata = d;
      #1;
      chk(cpu_ack == 1'b1 && mem_we == 1'b1, "R6 write-through strobe", {cpu_ack, mem_we}, 32'd3);
      chk(mem_addr == AW'(a) && mem_be == be, "R6 address and enables", {mem_addr, mem_be}, {AW'(a), be});
      chk(mem_wdata == d, "R6 data", mem_wdata, d);
      i = a % ENTRIES;
      if (tagm(a)) begin
         for (int b = 0; b < 4; b++) if (be[b]) md[i][8*b +: 8] = d[8*b +: 8];
         mb[i] = mb[i] & ~be;
      end
   endtask

   task automatic inv(input int a);
      @(negedge clk);
      cpu_req = 0; inv_en = 1; inv_addr = AW'(a);
      @(negedge clk);
      inv_en = 0;
      mv[a % ENTRIES] = 0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < ENTRIES; i++) begin mv[i] = 0; mt[i] = 0; md[i] = '0; mb[i] = '0; end
      rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_be = 0; cpu_addr = 0; cpu_wdata = 0;
      fill_valid = 0; fill_data = 0; fill_par = 0; inv_en = 0; inv_addr = 0;
      repeat (3) @(negedge clk);
      #1;
      chk({cpu_ack, fill_req, mem_we, par_err} == 4'b0, "R1 reset idle",
          {cpu_ack, fill_req, mem_we, par_err}, 32'd0);
      @(negedge clk);
      rst_n = 1;

      read_fill(8'h05, -1, 0, "R1 first read misses");
      read_fill(8'h0A, -1, 1, "R3 miss");
      for (int i = 0; i < ENTRIES; i++) access(i, "R2 sweep hit");

      // every byte-enable pattern once
      for (int i = 0; i < ENTRIES; i++) wr(i, 4'(i), ~pat(i) ^ 32'h00FF00FF);
      for (int i = 0; i < ENTRIES; i++) access(i, "R7 merged readback");

      wr(8'h32, 4'hF, 32'h12345678);
      read_fill(8'h32, -1, 0, "R8 store miss left no entry");
      read_fill(8'h02, -1, 0, "R11 alias evicted");

      read_fill(8'h59, 1, 0, "R9 requested word bad");
      read_fill(8'h7C, 6, 0, "R11 new tag");
      access(8'h7E, "R9 neighbour bad");

      inv(8'h7B);
      access(8'h7A, "R10 neighbour still hits");
      read_fill(8'h7B, -1, 0, "R10 invalidated word misses");

      for (int i = 0; i < ENTRIES; i++) access(8'h70 + i, "R4 final sweep");

      @(negedge clk);
      cpu_req = 0;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule